// File: doc/BRIEF.md
# Receive Buffer Resource Ring Manager

This block keeps track of where received frames may be placed in memory. Software builds a circular table of buffer resources; each resource names a buffer area by a 32-bit start address and a 32-bit length counted in 16-bit words. Four pointer registers describe the ring: its first entry, the position just past its last entry, the entry to be fetched next, and the first entry that software has not yet handed over. On a fetch request the block reads the next four-word entry through a simple request/acknowledge memory read port. It then loads the current buffer address and the remaining word count, and moves the fetch pointer on, wrapping it to the start of the ring.

For every received frame a length arrives on a ready/valid input. The block works out the stored length, which is the frame plus its 4-byte check sequence, rounded up to the bus width. It decides whether the frame fits and reports the buffer address at which the frame starts. It advances the buffer address and the word count. When the buffer runs low or overflows, it either fetches the next resource automatically or stops taking frames until software supplies more. Writing the frame bytes and the pad bytes (value 0xFF) into memory, and handling the receive descriptors, belong to neighbouring blocks.

Top module: `rx_buf_ring`

## Requirements
- R1: A write to a ring pointer register (select 0 start, 1 end, 2 fetch pointer, 3 software limit) stores the value with bit 0 cleared in 16-bit mode and bits 1:0 cleared in 32-bit mode. The fetch pointer is visible on `read_ptr` from the cycle after the write.
- R2: A fetch reads four words at the fetch pointer plus 0, 1, 2 and 3 times the word stride (2 bytes in 16-bit mode, 4 bytes in 32-bit mode). The words are taken in this order: address low, address high, count low, count high. They then become `buf_addr` and `buf_words`.
- R3: When a fetch completes, the fetch pointer moves on by 8 bytes (16-bit mode) or 16 bytes (32-bit mode). If the result equals the end register, it is reloaded from the start register. At all other times it changes only through a register write.
- R4: `sts_exhausted` pulses for one cycle, in the cycle after a fetch completes, when the updated fetch pointer equals the software limit register.
- R5: The stored length `res_len` is the frame byte count plus 4, rounded up to a multiple of 2 bytes in 16-bit mode or 4 bytes in 32-bit mode.
- R6: A frame fits when its stored length is at most twice `buf_words`. A fitting frame is reported with `res_stored`=1 and `res_pkt_ptr` equal to the buffer address before the frame. `buf_addr` then grows by the stored length and `buf_words` drops by half of it.
- R7: After a stored frame, `last_pkt` is 1 exactly when the remaining word count is strictly below `low_water`. A remaining count equal to `low_water` leaves `last_pkt` at 0.
- R8: A frame that does not fit is not stored. It pulses `sts_area_exceeded`, sets `last_pkt`, and leaves `buf_addr` and `buf_words` unchanged.
- R9: When `last_pkt` is set and the fetch pointer differs from the software limit, the next resource is fetched without a request.
- R10: When `last_pkt` is set and the fetch pointer equals the software limit, `rx_stopped` goes to 1. Frames are then reported with `res_stored`=0, with no status pulse and no change to the buffer. This lasts until a fetch completes, which clears `rx_stopped`.
- R11: `frm_ready` is 0 while a fetch is pending or running. A frame held valid during that time is taken after the fetch, against the newly loaded buffer.
- R12: After reset all pointers, `buf_addr` and `buf_words` are 0. `frm_ready` is 1, and `mem_rd_req`, `rx_stopped`, `last_pkt` and all pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1: 32-bit memory mode, 0: 16-bit mode |
| cfg_we | input | 1 | Ring pointer register write strobe |
| cfg_sel | input | 2 | Register select: 0 start, 1 end, 2 fetch pointer, 3 software limit |
| cfg_wdata | input | PTR_W | Pointer write value (byte address) |
| low_water | input | 2*DW | Remaining-word threshold |
| fetch_req | input | 1 | Request to fetch the next resource |
| mem_rd_req | output | 1 | Memory read request, held until acknowledged |
| mem_rd_addr | output | PTR_W | Memory read byte address |
| mem_rd_ack | input | 1 | One-cycle read acknowledge, data valid |
| mem_rd_data | input | DW | Read data |
| frm_valid | input | 1 | Frame length valid |
| frm_ready | output | 1 | Frame length accepted this cycle when valid |
| frm_bytes | input | BYTE_W | Received frame byte count without check sequence |
| res_valid | output | 1 | One-cycle frame result |
| res_stored | output | 1 | Frame placed in the buffer |
| res_pkt_ptr | output | 2*DW | Buffer address at which the frame starts |
| res_len | output | BYTE_W+1 | Padded stored length in bytes |
| buf_addr | output | 2*DW | Current buffer address |
| buf_words | output | 2*DW | Remaining words in the current buffer |
| read_ptr | output | PTR_W | Current fetch pointer |
| last_pkt | output | 1 | Last frame that fits the current buffer |
| rx_stopped | output | 1 | Reception halted for lack of resources |
| sts_exhausted | output | 1 | Pulse: fetch pointer reached the software limit |
| sts_area_exceeded | output | 1 | Pulse: frame did not fit the buffer |

## Verification
The assertions assume that the memory answers every read request with exactly one acknowledge and drops no request. They also assume that `wide_mode` is changed only while no fetch and no frame is in flight. Software is assumed to program the end register to a value the fetch pointer actually reaches by whole entry strides. The stimulus meets these conditions: a responder acknowledges each request one cycle after it is raised, the mode changes only between scenarios while the block is idle, and every ring is laid out on entry boundaries.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

  typedef enum logic [1:0] {
    PSEL_START = 2'd0,
    PSEL_END   = 2'd1,
    PSEL_READ  = 2'd2,
    PSEL_LIMIT = 2'd3
  } psel_e;

  localparam int RING_REGS   = 4;
  localparam int ENTRY_WORDS = 4;
  localparam int FCS_BYTES   = 4;

  // byte distance between consecutive 16-bit fields in memory
  function automatic int unsigned word_stride(input logic wide);
    return wide ? 4 : 2;
  endfunction

  // byte distance between consecutive ring entries
  function automatic int unsigned entry_stride(input logic wide);
    return ENTRY_WORDS * word_stride(wide);
  endfunction

  // pointer alignment applied on register writes
  function automatic logic [31:0] align_ptr(input logic [31:0] p, input logic wide);
    return wide ? (p & ~32'd3) : (p & ~32'd1);
  endfunction

  // stored length: frame plus check sequence, rounded to bus width
  function automatic logic [31:0] padded_len(input logic [31:0] nbytes, input logic wide);
    logic [31:0] raw;
    raw = nbytes + FCS_BYTES;
    return wide ? ((raw + 32'd3) & ~32'd3) : ((raw + 32'd1) & ~32'd1);
  endfunction

endpackage

// File: rtl/rbr_ptr_regs.sv
module rbr_ptr_regs
  import rbr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [PTR_W-1:0] cfg_wdata,
  input  logic             adv,
  output logic [PTR_W-1:0] rrp,
  output logic             adv_hits_limit,
  output logic             rrp_at_limit
);
  logic [PTR_W-1:0] ptr_q [RING_REGS];
  logic [PTR_W-1:0] stepped;
  logic [PTR_W-1:0] rrp_adv;
  logic [PTR_W-1:0] wr_val;

  assign wr_val  = PTR_W'(align_ptr(32'(cfg_wdata), wide));
  assign stepped = ptr_q[PSEL_READ] + PTR_W'(entry_stride(wide));
  assign rrp_adv = (stepped == ptr_q[PSEL_END]) ? ptr_q[PSEL_START] : stepped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RING_REGS; i++) ptr_q[i] <= '0;
    end else begin
      for (int i = 0; i < RING_REGS; i++) begin
        if (cfg_we && cfg_sel == 2'(i))
          ptr_q[i] <= wr_val;
        else if (adv && i == int'(PSEL_READ))
          ptr_q[i] <= rrp_adv;
      end
    end
  end

  assign rrp            = ptr_q[PSEL_READ];
  assign adv_hits_limit = (rrp_adv == ptr_q[PSEL_LIMIT]);
  assign rrp_at_limit   = (ptr_q[PSEL_READ] == ptr_q[PSEL_LIMIT]);
endmodule

// File: rtl/rbr_fetch.sv
module rbr_fetch
  import rbr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int PTR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              start,
  input  logic [PTR_W-1:0]  base,
  output logic              mem_rd_req,
  output logic [PTR_W-1:0]  mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic [2*DW-1:0]   entry_addr,
  output logic [2*DW-1:0]   entry_cnt
);
  localparam int IDX_W = $clog2(ENTRY_WORDS);

  typedef enum logic [1:0] {FS_IDLE, FS_READ, FS_FIN} fstate_e;
  fstate_e           state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DW-1:0]     word_q [ENTRY_WORDS];
  logic              last_word;

  assign last_word = (idx_q == IDX_W'(ENTRY_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        FS_IDLE: if (start) begin
          state_q <= FS_READ;
          idx_q   <= '0;
        end
        FS_READ: if (mem_rd_ack) begin
          idx_q <= idx_q + 1'b1;
          if (last_word) state_q <= FS_FIN;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRY_WORDS; i++) word_q[i] <= '0;
    end else if (state_q == FS_READ && mem_rd_ack) begin
      for (int i = 0; i < ENTRY_WORDS; i++)
        if (idx_q == IDX_W'(i)) word_q[i] <= mem_rd_data;
    end
  end

  assign mem_rd_req  = (state_q == FS_READ);
  assign mem_rd_addr = base + PTR_W'(32'(idx_q) * word_stride(wide));
  assign busy        = (state_q != FS_IDLE);
  assign done        = (state_q == FS_FIN);
  assign entry_addr  = {word_q[1], word_q[0]};
  assign entry_cnt   = {word_q[3], word_q[2]};
endmodule

// File: rtl/rbr_frame_acct.sv
module rbr_frame_acct
  import rbr_pkg::*;
#(
  parameter int BYTE_W = 16,
  parameter int BUF_W  = 32
) (
  input  logic              wide,
  input  logic [BYTE_W-1:0] frame_bytes,
  input  logic [BUF_W-1:0]  cur_addr,
  input  logic [BUF_W-1:0]  cur_words,
  input  logic [BUF_W-1:0]  low_water,
  output logic [BYTE_W:0]   pad_len,
  output logic              fits,
  output logic [BUF_W-1:0]  next_addr,
  output logic [BUF_W-1:0]  next_words,
  output logic              below
);
  assign pad_len    = (BYTE_W+1)'(padded_len(32'(frame_bytes), wide));
  assign fits       = (BUF_W+1)'(pad_len) <= {cur_words, 1'b0};
  assign next_addr  = cur_addr + BUF_W'(pad_len);
  assign next_words = cur_words - BUF_W'(pad_len >> 1);
  assign below      = (next_words < low_water);
endmodule

// File: rtl/rx_buf_ring.sv
module rx_buf_ring
  import rbr_pkg::*;
#(
  parameter int DW     = 16,
  parameter int PTR_W  = 16,
  parameter int BYTE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PTR_W-1:0]  cfg_wdata,
  input  logic [2*DW-1:0]   low_water,
  input  logic              fetch_req,
  output logic              mem_rd_req,
  output logic [PTR_W-1:0]  mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [DW-1:0]     mem_rd_data,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [BYTE_W-1:0] frm_bytes,
  output logic              res_valid,
  output logic              res_stored,
  output logic [2*DW-1:0]   res_pkt_ptr,
  output logic [BYTE_W:0]   res_len,
  output logic [2*DW-1:0]   buf_addr,
  output logic [2*DW-1:0]   buf_words,
  output logic [PTR_W-1:0]  read_ptr,
  output logic              last_pkt,
  output logic              rx_stopped,
  output logic              sts_exhausted,
  output logic              sts_area_exceeded
);
  localparam int BUF_W = 2 * DW;
  localparam int LEN_W = BYTE_W + 1;

  logic             fetch_busy, fetch_done, fetch_go;
  logic [BUF_W-1:0] entry_addr, entry_cnt;
  logic             adv_hits_limit, rrp_at_limit;
  logic [LEN_W-1:0] pad_len;
  logic             fits, below;
  logic [BUF_W-1:0] next_addr, next_words;

  logic             frm_take, frm_store, frm_over, lp_set;
  logic             auto_go_q, stopped_q, last_pkt_q;
  logic [BUF_W-1:0] addr_q, words_q;
  logic             rv_q, rs_q, exh_q, bae_q;
  logic [BUF_W-1:0] rptr_q;
  logic [LEN_W-1:0] rlen_q;

  rbr_ptr_regs #(.PTR_W(PTR_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wide(wide_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .adv(fetch_done), .rrp(read_ptr),
    .adv_hits_limit(adv_hits_limit), .rrp_at_limit(rrp_at_limit)
  );

  rbr_fetch #(.DW(DW), .PTR_W(PTR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .wide(wide_mode),
    .start(fetch_go), .base(read_ptr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .busy(fetch_busy), .done(fetch_done),
    .entry_addr(entry_addr), .entry_cnt(entry_cnt)
  );

  rbr_frame_acct #(.BYTE_W(BYTE_W), .BUF_W(BUF_W)) u_acct (
    .wide(wide_mode), .frame_bytes(frm_bytes),
    .cur_addr(addr_q), .cur_words(words_q), .low_water(low_water),
    .pad_len(pad_len), .fits(fits),
    .next_addr(next_addr), .next_words(next_words), .below(below)
  );

  assign fetch_go  = (fetch_req || auto_go_q) && !fetch_busy;
  assign frm_ready = !fetch_busy && !auto_go_q && !fetch_req;
  assign frm_take  = frm_valid && frm_ready;
  assign frm_store = frm_take && !stopped_q && fits;
  assign frm_over  = frm_take && !stopped_q && !fits;
  assign lp_set    = (frm_store && below) || frm_over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      words_q    <= '0;
      stopped_q  <= 1'b0;
      auto_go_q  <= 1'b0;
      last_pkt_q <= 1'b0;
      rv_q       <= 1'b0;
      rs_q       <= 1'b0;
      rptr_q     <= '0;
      rlen_q     <= '0;
      exh_q      <= 1'b0;
      bae_q      <= 1'b0;
    end else begin
      rv_q  <= frm_take;
      rs_q  <= frm_store;
      bae_q <= frm_over;
      exh_q <= fetch_done && adv_hits_limit;
      if (fetch_go) auto_go_q <= 1'b0;
      if (fetch_done) begin
        addr_q    <= entry_addr;
        words_q   <= entry_cnt;
        stopped_q <= 1'b0;
      end
      if (frm_take) begin
        last_pkt_q <= lp_set;
        rlen_q     <= pad_len;
        rptr_q     <= addr_q;
      end
      if (frm_store) begin
        addr_q  <= next_addr;
        words_q <= next_words;
      end
      if (lp_set) begin
        if (rrp_at_limit) stopped_q <= 1'b1;
        else              auto_go_q <= 1'b1;
      end
    end
  end

  assign res_valid         = rv_q;
  assign res_stored        = rs_q;
  assign res_pkt_ptr       = rptr_q;
  assign res_len           = rlen_q;
  assign buf_addr          = addr_q;
  assign buf_words         = words_q;
  assign last_pkt          = last_pkt_q;
  assign rx_stopped        = stopped_q;
  assign sts_exhausted     = exh_q;
  assign sts_area_exceeded = bae_q;
endmodule

// File: rtl/rbr_chk.sv
module rbr_chk #(
  parameter int BUF_W = 32,
  parameter int LEN_W = 17,
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             fetch_done,
  input logic             frm_take,
  input logic             frm_ready,
  input logic             mem_rd_req,
  input logic             res_valid,
  input logic             res_stored,
  input logic [BUF_W-1:0] res_pkt_ptr,
  input logic [LEN_W-1:0] res_len,
  input logic [BUF_W-1:0] buf_addr,
  input logic [PTR_W-1:0] read_ptr,
  input logic             last_pkt,
  input logic             rx_stopped,
  input logic             sts_exhausted,
  input logic             sts_area_exceeded
);
  // R11
  ready_vs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |-> !mem_rd_req);

  // R6
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_stored) |-> (buf_addr == res_pkt_ptr + BUF_W'(res_len)));

  // R5
  len_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_len[0] == 1'b0));

  // R8
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_area_exceeded |-> (res_valid && !res_stored && last_pkt));

  // R4
  exhaust_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_exhausted |-> $past(fetch_done));

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_done && !cfg_we) |=> $stable(read_ptr));

  // R10
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stopped && frm_take) |=> (res_valid && !res_stored && !sts_area_exceeded));
endmodule

bind rx_buf_ring rbr_chk #(
  .BUF_W(2*DW), .LEN_W(BYTE_W+1), .PTR_W(PTR_W)
) u_rbr_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .fetch_done(fetch_done),
  .frm_take(frm_take), .frm_ready(frm_ready), .mem_rd_req(mem_rd_req),
  .res_valid(res_valid), .res_stored(res_stored), .res_pkt_ptr(res_pkt_ptr),
  .res_len(res_len), .buf_addr(buf_addr), .read_ptr(read_ptr),
  .last_pkt(last_pkt), .rx_stopped(rx_stopped),
  .sts_exhausted(sts_exhausted), .sts_area_exceeded(sts_area_exceeded)
);

// File: tb/test_rx_buf_ring.sv
module test_rx_buf_ring;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic [31:0] low_water = 32'h10;
  logic        fetch_req = 1'b0;
  logic        mem_rd_req;
  logic [15:0] mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [15:0] mem_rd_data = '0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [15:0] frm_bytes = '0;
  logic        res_valid, res_stored;
  logic [31:0] res_pkt_ptr;
  logic [16:0] res_len;
  logic [31:0] buf_addr, buf_words;
  logic [15:0] read_ptr;
  logic        last_pkt, rx_stopped, sts_exhausted, sts_area_exceeded;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] mem [128];
  logic [15:0] rd_log [64];
  int rd_cnt = 0;

  always #5 clk = ~clk;

  rx_buf_ring i_rx_buf_ring (.*);

  // memory responder: acknowledge one cycle after each request
  always @(posedge clk) begin
    if (mem_rd_req && !mem_rd_ack) begin
      mem_rd_ack  <= 1'b1;
      mem_rd_data <= mem[mem_rd_addr[7:1]];
      rd_log[rd_cnt[5:0]] <= mem_rd_addr;
      rd_cnt <= rd_cnt + 1;
    end else begin
      mem_rd_ack <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (!frm_ready) @(negedge clk);
  endtask

  task automatic do_fetch();
    @(negedge clk);
    fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
    wait_idle();
  endtask

  task automatic send_frame(input logic [15:0] nb);
    @(negedge clk);
    frm_valid = 1'b1; frm_bytes = nb;
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 buf_addr", buf_addr, 0);
    chk("R12 buf_words", buf_words, 0);
    chk("R12 read_ptr", read_ptr, 0);
    chk("R12 frm_ready", frm_ready, 1);
    chk("R12 mem_rd_req", mem_rd_req, 0);
    chk("R12 stopped/last/pulses", {rx_stopped, last_pkt, sts_exhausted, sts_area_exceeded, res_valid}, 0);
  endtask

  task automatic t_mask();
    cfg_write(2'd2, 16'h0013);
    chk("R1 narrow mask", read_ptr, 16'h0012);
    wide_mode = 1'b1;
    cfg_write(2'd2, 16'h0017);
    chk("R1 wide mask", read_ptr, 16'h0014);
    wide_mode = 1'b0;
  endtask

  task automatic t_fetch_narrow();
    int base;
    cfg_write(2'd0, 16'h0020);
    cfg_write(2'd1, 16'h0030);
    cfg_write(2'd2, 16'h0020);
    cfg_write(2'd3, 16'h0010);
    base = rd_cnt;
    do_fetch();
    chk("R4 no exhaust", sts_exhausted, 0);
    chk("R2 read count", rd_cnt - base, 4);
    for (int k = 0; k < 4; k++) chk("R2 read addr", rd_log[(base + k) % 64], 16'h0020 + 16'(2 * k));
    chk("R2 buf_addr", buf_addr, 32'h0000_1000);
    chk("R2 buf_words", buf_words, 32'h40);
    chk("R3 step 8", read_ptr, 16'h0028);
  endtask

  task automatic t_frames_thresh();
    int base;
    send_frame(16'd13);
    chk("R6 stored", res_stored, 1);
    chk("R5 len 13", res_len, 18);
    chk("R6 ptr", res_pkt_ptr, 32'h1000);
    chk("R6 words", buf_words, 32'h37);
    send_frame(16'd60);
    chk("R5 len 60", res_len, 64);
    chk("R6 addr", buf_addr, 32'h1052);
    chk("R6 words", buf_words, 32'h17);
    send_frame(16'd10);
    chk("R7 equal threshold", last_pkt, 0);
    chk("R7 words", buf_words, 32'h10);
    base = rd_cnt;
    send_frame(16'd0);
    chk("R7 below threshold", last_pkt, 1);
    chk("R6 ptr", res_pkt_ptr, 32'h1060);
    wait_idle();
    chk("R9 auto reads", rd_cnt - base, 4);
    chk("R9 first addr", rd_log[base % 64], 16'h0028);
    chk("R9 buf_addr", buf_addr, 32'h0002_2000);
    chk("R9 buf_words", buf_words, 32'h0001_0000);
    chk("R3 wrap", read_ptr, 16'h0020);
  endtask

  task automatic t_exceed_stop();
    cfg_write(2'd3, 16'h0028);
    do_fetch();
    chk("R4 exhausted", sts_exhausted, 1);
    chk("R4 buf", buf_addr, 32'h1000);
    send_frame(16'd200);
    chk("R8 area exceeded", sts_area_exceeded, 1);
    chk("R8 not stored", {res_valid, res_stored}, 2'b10);
    chk("R8 last_pkt", last_pkt, 1);
    chk("R8 buf_addr kept", buf_addr, 32'h1000);
    chk("R8 buf_words kept", buf_words, 32'h40);
    chk("R10 stopped", rx_stopped, 1);
    chk("R10 no auto fetch", mem_rd_req, 0);
    send_frame(16'd10);
    chk("R10 dropped", {res_valid, res_stored, sts_area_exceeded}, 3'b100);
    chk("R10 buf unchanged", buf_addr, 32'h1000);
    chk("R10 still stopped", rx_stopped, 1);
    do_fetch();
    chk("R10 cleared by fetch", rx_stopped, 0);
    chk("R3 wrap again", read_ptr, 16'h0020);
    chk("R4 not at limit", sts_exhausted, 0);
    send_frame(16'd10);
    chk("R10 resumed", res_stored, 1);
    chk("R6 ptr", res_pkt_ptr, 32'h0002_2000);
  endtask

  task automatic t_wide();
    int base;
    wide_mode = 1'b1;
    cfg_write(2'd0, 16'h0040);
    cfg_write(2'd1, 16'h0080);
    cfg_write(2'd3, 16'h0000);
    cfg_write(2'd2, 16'h0040);
    base = rd_cnt;
    do_fetch();
    for (int k = 0; k < 4; k++) chk("R2 wide addr", rd_log[(base + k) % 64], 16'h0040 + 16'(4 * k));
    chk("R3 step 16", read_ptr, 16'h0050);
    chk("R2 wide words", buf_words, 32'h12);
    send_frame(16'd29);
    chk("R5 wide len", res_len, 36);
    chk("R6 exact fit", res_stored, 1);
    chk("R6 ptr", res_pkt_ptr, 32'h3000);
    chk("R7 words zero", buf_words, 0);
    chk("R7 last", last_pkt, 1);
    wait_idle();
    chk("R9 wide auto", read_ptr, 16'h0060);
  endtask

  task automatic t_handshake();
    @(negedge clk);
    fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
    frm_valid = 1'b1; frm_bytes = 16'd4;
    chk("R11 ready low in fetch", frm_ready, 0);
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
    chk("R11 taken after fetch", res_valid, 1);
    chk("R11 new buffer ptr", res_pkt_ptr, 32'h4000);
    chk("R5 wide len 4", res_len, 8);
    chk("R6 addr", buf_addr, 32'h4008);
    chk("R3 ptr", read_ptr, 16'h0070);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    mem[8'h20 >> 1] = 16'h1000; mem[8'h22 >> 1] = 16'h0000;
    mem[8'h24 >> 1] = 16'h0040; mem[8'h26 >> 1] = 16'h0000;
    mem[8'h28 >> 1] = 16'h2000; mem[8'h2a >> 1] = 16'h0002;
    mem[8'h2c >> 1] = 16'h0000; mem[8'h2e >> 1] = 16'h0001;
    mem[8'h40 >> 1] = 16'h3000; mem[8'h44 >> 1] = 16'h0000;
    mem[8'h48 >> 1] = 16'h0012; mem[8'h4c >> 1] = 16'h0000;
    mem[8'h60 >> 1] = 16'h4000; mem[8'h64 >> 1] = 16'h0000;
    mem[8'h68 >> 1] = 16'h0100; mem[8'h6c >> 1] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_fetch_narrow();
    t_frames_thresh();
    t_exceed_stop();
    t_wide();
    t_handshake();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule